// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small processor that completes one instruction per clock. On every rising edge it fetches a 32-bit word from its own instruction store, decodes it in one of three fixed formats (register, immediate or jump), reads two operands from a 32-entry register file of 32-bit words, and commits the result in the same cycle. Only loads and stores touch the data store. The instruction subset is add, sub, addi, lw, sw, bne and j. Any other encoding advances the PC and changes nothing else.

Both stores are word arrays inside the block. They are filled through a preload port while reset is held low. A combinational debug port exposes any register, so a program's effect can be observed from outside without extra instructions. Addresses are byte addresses. The word index is taken from bits above the two lowest, and it wraps at the depth of each store.

Top module: `risc32_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and every register is cleared to 0.
- R2: An instruction with opcode bits [31:26] = 0 and funct bits [5:0] = 32 writes RF[rd] = RF[rs] + RF[rt]. With funct 34 it writes RF[rs] - RF[rt]. The fields are rs [25:21], rt [20:16] and rd [15:11].
- R3: Opcode 8 writes RF[rt] = RF[rs] + the sign-extended immediate [15:0].
- R4: Opcode 35 loads RF[rt] from the data word at byte address RF[rs] + sign-extended offset. Opcode 43 stores RF[rt] there. The word index is address bits [DAW+1:2] and the two low bits are ignored.
- R5: Register 0 always reads as 0, and a write aimed at it is discarded.
- R6: For opcode 5, if RF[rs] differs from RF[rt], the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise it is PC + 4.
- R7: For opcode 2, the next PC is {(PC+4)[31:28], target[25:0], 2'b00}.
- R8: Every other opcode, or any other funct with opcode 0, changes no register or data word and advances the PC by 4. The PC is always word aligned.
- R9: While `rst_n` is low and `load_en` is high, `load_data` is written to word `load_idx` of the instruction store (`load_dmem` = 0) or of the data store (`load_dmem` = 1). While `rst_n` is high, the preload port has no effect.
- R10: `dbg_data` equals RF[`dbg_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Preload write strobe, honoured only in reset |
| load_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_idx | input | LAW | Word index of the preload write |
| load_data | input | 32 | Word written by the preload port |
| dbg_addr | input | 5 | Register selected for the debug port |
| dbg_data | output | 32 | Value of the selected register |
| pc_o | output | 32 | Current program counter |

## Verification
An instruction can name its own destination as a source, as in add r1,r1,r1. In that one cycle the register file must supply the old value on its read ports and capture the new value at the edge. The bench provokes this with a directed case and, in the random programs, by drawing all register numbers from a pool of eight, so that read-after-write and self-overwrite occur often. Each cycle is judged against a bench reference model that steps the same program: it compares the PC and the destination register after every edge, and all 32 registers at the end. The preload port is also driven with noise during execution to show that it is ignored.

// File: rtl/risc32_pkg.sv
`timescale 1ns/1ps
// Shared encodings and control word for the single-cycle core.
// Assumes the fixed 32-bit three-format layout with opcode in [31:26].
package risc32_pkg;
    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;
    localparam logic [5:0] FN_ADD   = 6'd32;
    localparam logic [5:0] FN_SUB   = 6'd34;

    typedef enum logic [1:0] {PC_SEQ, PC_BNE, PC_JUMP} pc_sel_e;

    typedef struct packed {
        logic    rf_we;    // instruction writes a register
        logic    dst_rd;   // destination is rd (else rt)
        logic    use_imm;  // second ALU operand is the immediate
        logic    alu_sub;  // ALU subtracts
        logic    mem_rd;   // result comes from data store
        logic    mem_wr;   // write data store
        pc_sel_e pc_sel;   // next-PC source
    } ctrl_t;
endpackage

// File: rtl/risc32_decode.sv
`timescale 1ns/1ps
// Instruction decoder: maps opcode and funct to a control word.
// Assumes unknown encodings must behave as a PC-advancing no-op.
module risc32_decode
    import risc32_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Produce control signals; default is a no-op with sequential PC.
    always_comb begin
        ctrl = '{rf_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, alu_sub: 1'b0,
                 mem_rd: 1'b0, mem_wr: 1'b0, pc_sel: PC_SEQ};
        case (opcode)
            OP_RTYPE: begin
                if (funct == FN_ADD || funct == FN_SUB) begin
                    ctrl.rf_we   = 1'b1;
                    ctrl.dst_rd  = 1'b1;
                    ctrl.alu_sub = (funct == FN_SUB);
                end
            end
            OP_ADDI: begin
                ctrl.rf_we   = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_LW: begin
                ctrl.rf_we   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BNE:  ctrl.pc_sel = PC_BNE;
            OP_JUMP: ctrl.pc_sel = PC_JUMP;
            default: ;
        endcase
    end
endmodule

// File: rtl/risc32_regfile.sv
`timescale 1ns/1ps
// Register file: one write port, three combinational read ports.
// Entry 0 is forced to read zero and never written; reset clears all entries.
module risc32_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NREGS)-1:0] ra1,
    output logic [W-1:0]             rd1,
    input  logic [$clog2(NREGS)-1:0] ra2,
    output logic [W-1:0]             rd2,
    input  logic [$clog2(NREGS)-1:0] ra3,
    output logic [W-1:0]             rd3
);
    localparam int AW = $clog2(NREGS);

    logic [W-1:0] regs [NREGS];

    // Clear on reset, otherwise capture a write not aimed at entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != AW'(0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Combinational reads with entry 0 hardwired to zero.
    always_comb begin
        rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
        rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];
        rd3 = (ra3 == AW'(0)) ? '0 : regs[ra3];
    end
endmodule

// File: rtl/risc32_wordmem.sv
`timescale 1ns/1ps
// Word array with one synchronous write port and one combinational read.
// Assumes no reset of contents; the owner fills it before use.
module risc32_wordmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    // Capture a write on the rising edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read of the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/risc32_core.sv
`timescale 1ns/1ps
// Single-cycle core for add, sub, addi, lw, sw, bne and j.
// Fetch, decode, execute, memory access and write-back all complete in one clock.
// Assumes both stores are preloaded through the load port while rst_n is low.
module risc32_core
    import risc32_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int LAW        = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic           load_dmem,
    input  logic [LAW-1:0] load_idx,
    input  logic [31:0]    load_data,
    input  logic [4:0]     dbg_addr,
    output logic [31:0]    dbg_data,
    output logic [31:0]    pc_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_res;
    logic [31:0] dmem_rdata, wb_data;
    logic [4:0]  rs, rt, rd, wb_addr;
    ctrl_t       ctrl;

    logic           imem_we, dmem_we;
    logic [DAW-1:0] dmem_waddr;
    logic [31:0]    dmem_wdata;

    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    assign imem_we = !rst_n && load_en && !load_dmem;

    risc32_wordmem #(.DEPTH(IMEM_WORDS), .W(32)) imem_i (
        .clk   (clk),
        .we    (imem_we),
        .waddr (load_idx[IAW-1:0]),
        .wdata (load_data),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    risc32_decode dec_i (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wb_addr = ctrl.dst_rd ? rd : rt;
    assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_res;

    risc32_regfile #(.NREGS(32), .W(32)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rst_n && ctrl.rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (rs),
        .rd1   (rs_val),
        .ra2   (rt),
        .rd2   (rt_val),
        .ra3   (dbg_addr),
        .rd3   (dbg_data)
    );

    // Adder shared by arithmetic and effective-address computation.
    always_comb begin
        alu_b   = ctrl.use_imm ? imm_sx : rt_val;
        alu_res = ctrl.alu_sub ? (rs_val - alu_b) : (rs_val + alu_b);
    end

    // Data-store write port: preload in reset, stores while running.
    always_comb begin
        if (!rst_n) begin
            dmem_we    = load_en && load_dmem;
            dmem_waddr = load_idx[DAW-1:0];
            dmem_wdata = load_data;
        end else begin
            dmem_we    = ctrl.mem_wr;
            dmem_waddr = alu_res[DAW+1:2];
            dmem_wdata = rt_val;
        end
    end

    risc32_wordmem #(.DEPTH(DMEM_WORDS), .W(32)) dmem_i (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_res[DAW+1:2]),
        .rdata (dmem_rdata)
    );

    // Select the next PC from sequential, PC-relative or pseudo-direct sources.
    always_comb begin
        pc_plus4   = pc_q + 32'd4;
        br_target  = pc_plus4 + {imm_sx[29:0], 2'b00};
        jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
        case (ctrl.pc_sel)
            PC_BNE:  pc_next = (rs_val != rt_val) ? br_target : pc_plus4;
            PC_JUMP: pc_next = jmp_target;
            default: pc_next = pc_plus4;
        endcase
    end

    // Program counter register with synchronous reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/risc32_core_chk.sv
`timescale 1ns/1ps
// Property checker for risc32_core, attached by bind.
// Observes the PC, the fetched word, operand values and the debug port.
module risc32_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_q,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [4:0]  dbg_addr,
    input logic [31:0] dbg_data
);
    logic [5:0]  op;
    logic [31:0] br_off;
    assign op     = instr[31:26];
    assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};

    AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_addr == 5'd0 |-> dbg_data == 32'd0); // R5

    AST_BNE_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd5 && rs_val != rt_val) |=> pc_q == $past(pc_q) + 32'd4 + $past(br_off)); // R6

    AST_BNE_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd5 && rs_val == rt_val) |=> pc_q == $past(pc_q) + 32'd4); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'd2 |=> pc_q[27:0] == {$past(instr[25:0]), 2'b00}); // R7

    AST_SEQUENTIAL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 6'd5 && op != 6'd2) |=> pc_q == $past(pc_q) + 32'd4); // R8

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00); // R8
endmodule

bind risc32_core risc32_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_q     (pc_q),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
);

// File: tb/risc32_core_tb_top.sv
`timescale 1ns/1ps
// Bench: directed and seeded-random programs checked against a reference model.
module risc32_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [5:0]  load_idx = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data, pc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] im_m [64];
    logic [31:0] dm_m [64];
    logic [31:0] rf_m [32];
    logic [31:0] pc_m;

    always #4 clk = ~clk;

    risc32_core dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dmem(load_dmem),
        .load_idx(load_idx), .load_data(load_data), .dbg_addr(dbg_addr),
        .dbg_data(dbg_data), .pc_o(pc_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'd2, tgt};
    endfunction

    // Reference model: executes the instruction at pc_m, reports class tag and destination.
    task automatic step(output string tag, output int dst);
        logic [31:0] ins, imm, ea, pc4;
        logic [5:0]  op, fn;
        int rs, rt, rd;
        ins = im_m[pc_m[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        imm = {{16{ins[15]}}, ins[15:0]};
        pc4 = pc_m + 32'd4;
        ea  = rf_m[rs] + imm;
        dst = -1; tag = "R8";
        if (op == 6'd0 && fn == 6'd32) begin
            dst = rd; tag = "R2"; if (rd != 0) rf_m[rd] = rf_m[rs] + rf_m[rt];
        end else if (op == 6'd0 && fn == 6'd34) begin
            dst = rd; tag = "R2"; if (rd != 0) rf_m[rd] = rf_m[rs] - rf_m[rt];
        end else if (op == 6'd8) begin
            dst = rt; tag = "R3"; if (rt != 0) rf_m[rt] = ea;
        end else if (op == 6'd35) begin
            dst = rt; tag = "R4"; if (rt != 0) rf_m[rt] = dm_m[ea[7:2]];
        end else if (op == 6'd43) begin
            tag = "R4"; dm_m[ea[7:2]] = rf_m[rt];
        end else if (op == 6'd5) begin
            tag = "R6";
            if (rf_m[rs] != rf_m[rt]) pc4 = pc4 + {imm[29:0], 2'b00};
        end else if (op == 6'd2) begin
            tag = "R7"; pc4 = {pc4[31:28], ins[25:0], 2'b00};
        end
        if (dst == 0) tag = "R5";
        pc_m = pc4;
    endtask

    // Hold reset, preload both stores, check the reset state (R1, R9).
    task automatic reset_and_load();
        @(negedge clk); rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_dmem = 1'b0; load_idx = 6'(i); load_data = im_m[i];
        end
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_dmem = 1'b1; load_idx = 6'(i); load_data = dm_m[i];
        end
        @(negedge clk); load_en = 1'b0;
        chk("R1", "pc in reset", pc_o, 32'd0);
        for (int r = 1; r < 32; r++) begin
            dbg_addr = 5'(r); #1;
            chk("R1", "reg cleared", dbg_data, 32'd0);
        end
        for (int r = 0; r < 32; r++) rf_m[r] = '0;
        pc_m = '0;
        rst_n = 1'b1;
    endtask

    // Run n cycles; noisy drives the preload port, which must be ignored (R9).
    task automatic run(input int n, input bit noisy);
        string tag;
        int dst;
        for (int c = 0; c < n; c++) begin
            step(tag, dst);
            if (noisy) begin
                load_en = 1'b1; load_dmem = 1'($urandom);
                load_idx = 6'($urandom); load_data = $urandom;
            end
            @(posedge clk);
            @(negedge clk);
            load_en = 1'b0;
            chk(tag, "pc", pc_o, pc_m);
            if (dst >= 0) begin
                dbg_addr = 5'(dst); #1;
                chk(tag, "dest reg", dbg_data, rf_m[dst]);
            end
        end
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r); #1;
            chk(noisy ? "R9" : "R10", "final reg", dbg_data, rf_m[r]);
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int k = int'($urandom % 9);
        int rs = int'($urandom % 8), rt = int'($urandom % 8), rd = int'($urandom % 8);
        case (k)
            0: return enc_r(rs, rt, rd, 6'd32);
            1: return enc_r(rs, rt, rd, 6'd34);
            2, 3: return enc_i(6'd8, rs, rt, 16'($urandom));
            4: return enc_i(6'd35, rs, rt, 16'($urandom));
            5: return enc_i(6'd43, rs, rt, 16'($urandom));
            6: return enc_i(6'd5, rs, rt, 16'(int'($urandom % 7) - 3));
            7: return enc_j(26'($urandom % 64));
            default: return ($urandom % 2 == 0) ? enc_r(rs, rt, rd, 6'd33)
                                                : enc_i(6'd15, rs, rt, 16'($urandom));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // Directed program.
        for (int i = 0; i < 64; i++) begin im_m[i] = '0; dm_m[i] = 32'h1000 + 32'(i); end
        dm_m[63] = 32'h0000_A5A5;
        im_m[0]  = enc_i(6'd8, 0, 1, 16'd5);        // R3 r1=5
        im_m[1]  = enc_i(6'd8, 0, 0, 16'd7);        // R5 write to r0 dropped
        im_m[2]  = enc_i(6'd8, 0, 2, 16'hFFFD);     // R3 sign extension, r2=-3
        im_m[3]  = enc_r(1, 2, 3, 6'd32);           // R2 r3=2
        im_m[4]  = enc_r(2, 1, 4, 6'd34);           // R2 r4=-8
        im_m[5]  = enc_r(1, 1, 1, 6'd32);           // R2 self overwrite r1=10
        im_m[6]  = enc_i(6'd43, 0, 4, 16'd8);       // R4 store to word 2
        im_m[7]  = enc_i(6'd35, 0, 5, 16'd8);       // R4 load back
        im_m[8]  = enc_i(6'd35, 3, 6, 16'hFFFC);    // R4 negative, unaligned -> word 63
        im_m[9]  = enc_i(6'd5, 1, 1, 16'd5);        // R6 not taken
        im_m[10] = enc_i(6'd5, 1, 3, 16'd2);        // R6 taken to 13
        im_m[11] = enc_i(6'd8, 0, 7, 16'd1);
        im_m[12] = enc_i(6'd8, 0, 7, 16'd2);
        im_m[13] = enc_j(26'd16);                   // R7
        im_m[14] = enc_i(6'd8, 0, 7, 16'd3);
        im_m[16] = enc_r(1, 3, 8, 6'd36);           // R8 unknown funct
        im_m[17] = enc_i(6'd12, 1, 9, 16'd4);       // R8 unknown opcode
        im_m[18] = enc_j(26'd18);                   // R7 self loop
        reset_and_load();
        run(24, 1'b1);
        chk("R4", "lw of stored word", rf_m[5], 32'hFFFF_FFF8);
        chk("R4", "unaligned lw wraps", rf_m[6], 32'h0000_A5A5);
        // Seeded random programs.
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 64; i++) begin im_m[i] = rand_instr(); dm_m[i] = $urandom; end
            reset_and_load();
            run(160, 1'b0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule